// File: doc/BRIEF.md
# Test-Port Byte ROM Readout Serializer

This block lets a boundary-scan host read a small on-chip constant table over the test port while the chip runs normally. It is driven by the strobes of one user data register of an external tap controller: capture, shift and update, all sampled on the rising test clock. The block is active only while a single opcode-match input is high. Without a match, every strobe is ignored and the serial output stays low.

A capture copies the byte at the active address, in parallel, into an output shift register. Each shift cycle then moves one bit onto the serial output, least significant bit first. While those bits leave, the bits arriving on the serial input fill a command register. This register holds a 7-bit address and a mode flag. On update, the mode flag chooses the next active address: either the address just shifted in, or the current address plus one. A host can therefore jump to any byte, or stream the whole table by repeating read frames that carry a zero flag.

The table is 128 bytes, and its contents are computed from the address. The read is combinational from the active address.

Top module: `jrr_top`

## Requirements
- R1: The table holds 128 bytes. The byte at address a is ((a*29 + 60) mod 256) XOR (a >> 2), and it is read combinationally from the active address.
- R2: A rising test clock with opcode_hit and dr_capture high loads the output shift register with the byte at the active address. From then on, scan_out shows that byte's bit 0.
- R3: Each rising test clock with opcode_hit and dr_shift high shifts the output register one place toward bit 0 and fills the top with 0. The byte therefore leaves least significant bit first, and after 8 shifts scan_out is 0.
- R4: During those same shift cycles, scan_in enters an 8-bit command register least significant bit first. After 8 shifts, command bits 6:0 hold the first seven bits sent (the address), and bit 7 holds the eighth bit (the mode flag).
- R5: A rising test clock with opcode_hit and dr_update high, while command bit 7 is 1, makes command bits 6:0 the active address.
- R6: An update while command bit 7 is 0 increments the active address by one, and address 127 wraps to 0.
- R7: While opcode_hit is low, capture, shift and update have no effect on the address, the command register or the output register, and scan_out is 0.
- R8: While rst_n is low, the active address, the command register and the output register are all cleared. After reset, scan_out is 0 and an update with no prior shift increments the address to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_hit | input | 1 | High while the user opcode is selected |
| dr_capture | input | 1 | Data-register capture strobe |
| dr_shift | input | 1 | Data-register shift strobe |
| dr_update | input | 1 | Data-register update strobe |
| scan_in | input | 1 | Serial command data in |
| scan_out | output | 1 | Serial read data out |

## Verification
A wrong active address does not show on the port when it arises. It shows in the next frame, as soon as the first bit of the captured byte appears on scan_out after the capture edge, and it persists in every later frame of an incrementing stream. A corrupted output register shows on the very next bit of the frame. A fault in the command register stays hidden until the update that uses it, so each external-address jump is confirmed by reading the byte at the target address. All 128 addresses are visited both by incrementing, including the wrap, and by direct jumps. Frames interrupted by a dropped opcode match check that no state moves while the match is low.

// File: rtl/jrr_pkg.sv
package jrr_pkg;
    localparam int unsigned ROM_MULT = 29;
    localparam int unsigned ROM_OFFS = 60;

    // Table contents as a function of address; callers truncate to data width.
    function automatic logic [31:0] rom_word(input logic [31:0] a);
        logic [31:0] lin;
        lin = ((a * ROM_MULT) + ROM_OFFS) & 32'h0000_00FF;
        return lin ^ (a >> 2);
    endfunction
endpackage

// File: rtl/jrr_rom.sv
module jrr_rom #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = DATA_W'(jrr_pkg::rom_word(32'(addr)));
    end
endmodule

// File: rtl/jrr_addr_ctrl.sv
module jrr_addr_ctrl #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              sin,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W:0]   cmd
);
    localparam int CMD_W = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.cmd = {sin, st_q.cmd[CMD_W-1:1]};
        end
        if (update_en) begin
            if (st_q.cmd[CMD_W-1]) begin
                st_d.addr = st_q.cmd[ADDR_W-1:0];
            end else begin
                st_d.addr = st_q.addr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr = st_q.addr;
    assign cmd  = st_q.cmd;
endmodule

// File: rtl/jrr_serializer.sv
module jrr_serializer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] pdata,
    output logic [DATA_W-1:0] word,
    output logic              sbit
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture_en) begin
            st_d.sh = pdata;
        end else if (shift_en) begin
            st_d.sh = {1'b0, st_q.sh[DATA_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.sh;
    assign sbit = st_q.sh[0];
endmodule

// File: rtl/jrr_top.sv
module jrr_top #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic tck,
    input  logic rst_n,
    input  logic opcode_hit,
    input  logic dr_capture,
    input  logic dr_shift,
    input  logic dr_update,
    input  logic scan_in,
    output logic scan_out
);
    logic              cap_g, shf_g, upd_g;
    logic [ADDR_W-1:0] act_addr;
    logic [ADDR_W:0]   cmd_word;
    logic [DATA_W-1:0] rom_data;
    logic [DATA_W-1:0] out_word;
    logic              out_bit;

    assign cap_g = opcode_hit & dr_capture;
    assign shf_g = opcode_hit & dr_shift;
    assign upd_g = opcode_hit & dr_update;

    jrr_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (tck),
        .rst_n     (rst_n),
        .shift_en  (shf_g),
        .update_en (upd_g),
        .sin       (scan_in),
        .addr      (act_addr),
        .cmd       (cmd_word)
    );

    jrr_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
        .addr  (act_addr),
        .rdata (rom_data)
    );

    jrr_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk        (tck),
        .rst_n      (rst_n),
        .capture_en (cap_g),
        .shift_en   (shf_g),
        .pdata      (rom_data),
        .word       (out_word),
        .sbit       (out_bit)
    );

    assign scan_out = opcode_hit & out_bit;
endmodule

// File: rtl/jrr_checker.sv
module jrr_checker #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input logic              tck,
    input logic              rst_n,
    input logic              opcode_hit,
    input logic              dr_capture,
    input logic              dr_shift,
    input logic              dr_update,
    input logic              scan_in,
    input logic              scan_out,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W:0]   cmd,
    input logic [DATA_W-1:0] word
);
    // R2: capture loads the byte at the active address
    a_r2_capture_loads: assert property (@(posedge tck) disable iff (!rst_n)
        (opcode_hit && dr_capture) |=> word == DATA_W'(jrr_pkg::rom_word(32'($past(addr)))));

    // R3: shift moves toward bit 0 with zero fill
    a_r3_shift_out: assert property (@(posedge tck) disable iff (!rst_n)
        (opcode_hit && dr_shift && !dr_capture) |=> word == {1'b0, $past(word[DATA_W-1:1])});

    // R4: serial input enters command register at the top
    a_r4_cmd_fill: assert property (@(posedge tck) disable iff (!rst_n)
        (opcode_hit && dr_shift) |=> cmd == {$past(scan_in), $past(cmd[ADDR_W:1])});

    // R5: external address load
    a_r5_ext_load: assert property (@(posedge tck) disable iff (!rst_n)
        (opcode_hit && dr_update && cmd[ADDR_W]) |=> addr == $past(cmd[ADDR_W-1:0]));

    // R6: increment with wrap
    a_r6_increment: assert property (@(posedge tck) disable iff (!rst_n)
        (opcode_hit && dr_update && !cmd[ADDR_W]) |=> addr == ADDR_W'($past(addr) + 1'b1));

    // R7: no match leaves state untouched and output low
    a_r7_hold: assert property (@(posedge tck) disable iff (!rst_n)
        !opcode_hit |=> ($stable(addr) && $stable(cmd) && $stable(word)));

    a_r7_out_low: assert property (@(posedge tck) disable iff (!rst_n)
        !opcode_hit |-> !scan_out);
endmodule

bind jrr_top jrr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .opcode_hit (opcode_hit),
    .dr_capture (dr_capture),
    .dr_shift   (dr_shift),
    .dr_update  (dr_update),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .addr       (act_addr),
    .cmd        (cmd_word),
    .word       (out_word)
);

// File: tb/jrr_top_test.sv
module jrr_top_test;
    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic opcode_hit = 1'b0;
    logic dr_capture = 1'b0;
    logic dr_shift = 1'b0;
    logic dr_update = 1'b0;
    logic scan_in = 1'b0;
    logic scan_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int model_addr = 0;

    always #10 tck = ~tck;

    jrr_top uut (
        .tck        (tck),
        .rst_n      (rst_n),
        .opcode_hit (opcode_hit),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .dr_update  (dr_update),
        .scan_in    (scan_in),
        .scan_out   (scan_out)
    );

    function automatic int exp_byte(input int a);
        return (((a * 29) + 60) % 256) ^ (a >> 2);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One full frame: capture, 8 shifts sending cmd, update. Returns the byte read.
    task automatic frame(input logic [7:0] cmd, output logic [7:0] got);
        @(negedge tck);
        dr_capture = 1'b1;
        @(negedge tck);
        dr_capture = 1'b0;
        for (int i = 0; i < 8; i++) begin
            got[i] = scan_out;
            scan_in = cmd[i];
            dr_shift = 1'b1;
            @(negedge tck);
        end
        dr_shift = 1'b0;
        check("R3 zero fill", int'(scan_out), 0);
        dr_update = 1'b1;
        @(negedge tck);
        dr_update = 1'b0;
        if (cmd[7]) model_addr = int'(cmd[6:0]);
        else model_addr = (model_addr + 1) % 128;
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge tck);
        rst_n = 1'b1;
        opcode_hit = 1'b1;
        @(negedge tck);
        // R8: reset state, output register clear
        check("R8 reset out", int'(scan_out), 0);
        // R8: update with empty command register increments to 1
        dr_update = 1'b1;
        @(negedge tck);
        dr_update = 1'b0;
        model_addr = 1;
        // R1 R2 R3 R6: stream 130 bytes by increment, crossing the wrap
        for (int k = 0; k < 130; k++) begin
            int e;
            e = exp_byte(model_addr);
            frame(8'h00, got);
            check("R2/R1/R6 stream byte", int'(got), e);
        end
        // R4 R5: jump to every address, read it back
        for (int a = 0; a < 128; a++) begin
            logic [7:0] c;
            c = {1'b1, 7'(127 - a)};
            frame(c, got);
            check("R4/R5 jump target", model_addr, 127 - a);
            frame(8'h00, got);
            check("R5 byte at jumped address", int'(got), exp_byte(127 - a));
        end
        // R6: explicit wrap from 127
        frame(8'hFF, got);
        frame(8'h00, got);
        check("R6 read at 127", int'(got), exp_byte(127));
        frame(8'h00, got);
        check("R6 wrap to 0", int'(got), exp_byte(0));
        // R7: capture a byte, then drop the match and toggle all strobes
        @(negedge tck);
        dr_capture = 1'b1;
        @(negedge tck);
        dr_capture = 1'b0;
        opcode_hit = 1'b0;
        for (int i = 0; i < 10; i++) begin
            dr_capture = i[0];
            dr_shift = 1'b1;
            dr_update = i[1];
            scan_in = 1'b1;
            @(negedge tck);
            check("R7 out low", int'(scan_out), 0);
        end
        dr_capture = 1'b0;
        dr_shift = 1'b0;
        dr_update = 1'b0;
        opcode_hit = 1'b1;
        @(negedge tck);
        for (int i = 0; i < 8; i++) begin
            got[i] = scan_out;
            scan_in = 1'b0;
            dr_shift = 1'b1;
            @(negedge tck);
        end
        dr_shift = 1'b0;
        check("R7 byte intact", int'(got), exp_byte(1));
        dr_update = 1'b1;
        @(negedge tck);
        dr_update = 1'b0;
        frame(8'h00, got);
        check("R7 address unchanged", int'(got), exp_byte(2));
        // R8: reset mid-stream returns to address 0 state
        rst_n = 1'b0;
        @(negedge tck);
        rst_n = 1'b1;
        @(negedge tck);
        check("R8 out after reset", int'(scan_out), 0);
        model_addr = 0;
        frame(8'h00, got);
        check("R8 address 0 after reset", int'(got), exp_byte(0));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule